// File: doc/BRIEF.md
# Indirect Redirection-Table Register Window

This block is the software-facing register front end of a 24-input interrupt redirection controller. Software sees only two 32-bit locations: an 8-bit select register and a data window. The value held in the select register decides what the window reaches. It can reach the controller's identification word, its version word, its arbitration identification word, or one 32-bit half of a 64-bit redirection entry. There is one entry per input pin.

The block holds the entries and presents them. It does not deliver interrupts. Delivery logic sets the two status bits of an entry through a small status-load port. Software writes can never overwrite those bits. When a software write leaves an entry in edge mode, the block clears that entry's remote-IRR bit. Neighbouring logic watches two one-cycle strobes. The first reports that an entry's mask bit changed. The second reports that an entry in level mode was rewritten, so the neighbour can decide whether to re-service a pending level input.

Top module: `irq_route_regs`

## Requirements
- R1: The select register sits at byte offset 0x00. A write stores only bits 7:0 of the write data, and a read at 0x00 returns the stored byte zero-extended.
- R2: Select value 0x01 reaches the version word. It reads as {8'h00, PINS-1, 8'h00, VERSION}, which is 0x00170011 with the defaults. Writes to it change nothing.
- R3: Select value 0x00 reaches a 4-bit ID held at bits 27:24; every other bit reads 0. Select value 0x02 returns the same word, and writes through 0x02 are dropped.
- R4: A select value s of 0x10 or above picks entry (s-0x10)>>1. An odd s reaches bits 63:32 of that entry and an even s reaches bits 31:0. Both halves are stored as written, apart from the bits covered by R6 and R7.
- R5: A select value that picks no entry reads 0xFFFFFFFF through the window, and a write to it changes no entry. This covers 0x03-0x0F and any index of PINS or above.
- R6: A software write keeps an entry's delivery-status bit (bit 12) and remote-IRR bit (bit 14) whatever the write data holds in those positions.
- R7: After any software write that leaves the entry's trigger bit (bit 15; 1 = level) at 0, the entry's remote-IRR bit reads 0.
- R8: Only address bits 7:0 are decoded. Byte offsets other than 0x00 and 0x10 read 0 and ignore writes.
- R9: After reset, every entry reads 0x00010000 in its low half (mask bit 16 set) and 0 in its high half. The select register and the ID are 0.
- R10: When a write changes an entry's mask bit, mask_evt is high for exactly the next cycle, with mask_evt_pin giving the entry and mask_evt_val the new mask value. Writes that leave the mask bit unchanged raise no strobe.
- R11: A write that leaves an entry in level mode raises lvl_evt for exactly the next cycle, with lvl_evt_pin giving the entry. A write that leaves the entry in edge mode raises no lvl_evt.
- R12: A status load (stat_we) with stat_pin selecting an entry writes stat_dlv into bit 12 and stat_rirr into bit 14. The load takes effect one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_wr | input | 1 | Write strobe for the current address and data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| stat_we | input | 1 | Status load from the delivery logic |
| stat_pin | input | IDX_W | Entry addressed by the status load |
| stat_rirr | input | 1 | Remote-IRR value to load |
| stat_dlv | input | 1 | Delivery-status value to load |
| mask_evt | output | 1 | One-cycle strobe: an entry's mask bit changed |
| mask_evt_pin | output | IDX_W | Entry whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| lvl_evt | output | 1 | One-cycle strobe: an entry in level mode was written |
| lvl_evt_pin | output | IDX_W | Entry that was written |

## Verification
The window is exercised with select values from every decode class: the three fixed registers, even and odd table selects at the first and last entries, the reserved gap 0x03-0x0F, and indices past the last pin. Together these separate an index or half-select error from an error in the out-of-range rule. Writes go in with the status bits set and cleared in the data, and to entries whose status bits were set through the load port. These patterns tell a design that preserves status bits apart from one that copies data bits or clears them. Edge and level writes, and writes that toggle or keep the mask bit, separate the two strobes from each other and from the remote-IRR clear. Aliased high address bits and unused offsets check that only the low byte is decoded.

// File: rtl/irw_pkg.sv
// Shared constants and types for the indirect redirection-table window.
// Assumes a 32-bit data window and 64-bit redirection entries.
package irw_pkg;

    localparam int ENTRY_W = 64;
    localparam int HALF_W  = 32;

    // Byte offsets decoded from the low address byte
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;

    // Select codes for the fixed registers and table base
    localparam logic [7:0] SEL_ID  = 8'h00;
    localparam logic [7:0] SEL_VER = 8'h01;
    localparam logic [7:0] SEL_ARB = 8'h02;
    localparam logic [7:0] SEL_TBL = 8'h10;

    // Entry field positions that the block's behaviour depends on
    localparam int B_DLV  = 12;
    localparam int B_RIRR = 14;
    localparam int B_TRIG = 15;
    localparam int B_MASK = 16;

    // ID field position inside the ID word
    localparam int ID_LSB = 24;
    localparam int ID_W   = 4;

    typedef enum logic [2:0] {
        WK_ID,
        WK_VER,
        WK_ARB,
        WK_TBL,
        WK_NONE
    } win_kind_e;

endpackage

// File: rtl/irw_decode.sv
// Address and select decode for the register window.
// Holds the 8-bit select register and turns it into a window target,
// a table index, a half selector and per-entry write enables.
// Assumes PINS <= 120 so that every table index fits in seven bits.
module irw_decode
    import irw_pkg::*;
#(
    parameter int PINS   = 24,
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [7:0]        sel_q,
    output logic              off_sel,
    output logic              off_win,
    output win_kind_e         kind,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic              tbl_hi,
    output logic              wr_id,
    output logic [PINS-1:0]   wr_lo_vec,
    output logic [PINS-1:0]   wr_hi_vec
);

    localparam logic [6:0] PINS_L = 7'(PINS);

    logic [7:0] off;
    logic [7:0] rel;
    logic [6:0] raw_idx;
    logic       win_wr;

    // Low byte of the address is the only decoded part
    assign off     = bus_addr[7:0];
    assign off_sel = (off == OFF_SEL);
    assign off_win = (off == OFF_WIN);
    assign win_wr  = bus_wr && off_win;

    // Table index and half from the select value
    assign rel     = sel_q - SEL_TBL;
    assign raw_idx = rel[7:1];
    assign tbl_idx = raw_idx[IDX_W-1:0];
    assign tbl_hi  = sel_q[0];

    // Classify what the window currently reaches
    always_comb begin
        case (sel_q)
            SEL_ID:  kind = WK_ID;
            SEL_VER: kind = WK_VER;
            SEL_ARB: kind = WK_ARB;
            default: kind = (sel_q >= SEL_TBL && raw_idx < PINS_L) ? WK_TBL : WK_NONE;
        endcase
    end

    assign wr_id = win_wr && (kind == WK_ID);

    // Select register keeps only the low data byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_wr && off_sel)
            sel_q <= bus_wdata[7:0];
    end

    // One write enable per entry half
    for (genvar i = 0; i < PINS; i++) begin : g_wen
        assign wr_lo_vec[i] = win_wr && (kind == WK_TBL) && (tbl_idx == IDX_W'(i)) && !tbl_hi;
        assign wr_hi_vec[i] = win_wr && (kind == WK_TBL) && (tbl_idx == IDX_W'(i)) &&  tbl_hi;
    end

    // R1: a select write stores the low byte of the data
    p_sel_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off_sel) |=> (sel_q == $past(bus_wdata[7:0])));

    // R5/R8: at most one entry half is written per cycle
    p_one_wen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo_vec, wr_hi_vec}));

endmodule

// File: rtl/irw_entry.sv
// One 64-bit redirection entry with software and status write paths.
// Software writes preserve the status bits; a write that leaves the entry
// in edge mode clears remote-IRR. Raises registered one-cycle strobes for
// a mask change and for a write that leaves the entry in level mode.
// Assumes at most one software half-write per cycle.
module irw_entry
    import irw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [HALF_W-1:0]  wdata,
    input  logic               stat_we,
    input  logic               stat_rirr,
    input  logic               stat_dlv,
    output logic [ENTRY_W-1:0] ent,
    output logic               mask_evt,
    output logic               lvl_evt
);

    logic [ENTRY_W-1:0] nxt;
    logic               sw_wr;

    assign sw_wr = wr_lo || wr_hi;

    // Next entry value: software data, preserved status, status load, edge clear
    always_comb begin
        nxt = ent;
        if (wr_lo) nxt[HALF_W-1:0]       = wdata;
        if (wr_hi) nxt[ENTRY_W-1:HALF_W] = wdata;
        nxt[B_DLV]  = ent[B_DLV];
        nxt[B_RIRR] = ent[B_RIRR];
        if (stat_we) begin
            nxt[B_DLV]  = stat_dlv;
            nxt[B_RIRR] = stat_rirr;
        end
        if (sw_wr && !nxt[B_TRIG])
            nxt[B_RIRR] = 1'b0;
    end

    // Entry storage; reset leaves only the mask bit set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent         <= '0;
            ent[B_MASK] <= 1'b1;
        end else begin
            ent <= nxt;
        end
    end

    // One-cycle strobes for mask change and level-mode rewrite
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_evt <= 1'b0;
            lvl_evt  <= 1'b0;
        end else begin
            mask_evt <= sw_wr && (nxt[B_MASK] != ent[B_MASK]);
            lvl_evt  <= sw_wr && nxt[B_TRIG];
        end
    end

    // R6: software writes leave delivery status untouched
    p_dlv_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !stat_we) |=> (ent[B_DLV] == $past(ent[B_DLV])));

    // R7: after a software write, an edge entry has no remote-IRR
    p_edge_rirr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (ent[B_TRIG] || !ent[B_RIRR]));

    // R10: a mask strobe always comes with a changed mask bit
    p_mask_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mask_evt) |-> (ent[B_MASK] != $past(ent[B_MASK])));

    // R11: a level strobe only accompanies a level-mode entry
    p_lvl_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_evt |-> ent[B_TRIG]);

endmodule

// File: rtl/irw_readmux.sv
// Read data path of the register window.
// Chooses between the select register, the window targets and zero for
// undecoded offsets; the window returns all ones for selects with no target.
// Assumes the picked entry is valid whenever kind is WK_TBL.
module irw_readmux
    import irw_pkg::*;
#(
    parameter int         PINS    = 24,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic               off_sel,
    input  logic               off_win,
    input  logic [7:0]         sel_q,
    input  win_kind_e          kind,
    input  logic               tbl_hi,
    input  logic [ID_W-1:0]    id_q,
    input  logic [ENTRY_W-1:0] ent_pick,
    output logic [HALF_W-1:0]  rdata
);

    localparam logic [7:0] MAXPIN = 8'(PINS - 1);

    logic [HALF_W-1:0] id_word;
    logic [HALF_W-1:0] ver_word;
    logic [HALF_W-1:0] win_word;

    assign id_word  = {{(HALF_W-ID_LSB-ID_W){1'b0}}, id_q, {ID_LSB{1'b0}}};
    assign ver_word = {8'h00, MAXPIN, 8'h00, VERSION};

    // Window value for the current select
    always_comb begin
        case (kind)
            WK_ID, WK_ARB: win_word = id_word;
            WK_VER:        win_word = ver_word;
            WK_TBL:        win_word = tbl_hi ? ent_pick[ENTRY_W-1:HALF_W] : ent_pick[HALF_W-1:0];
            default:       win_word = '1;
        endcase
    end

    // Offset selection for the bus read
    always_comb begin
        if (off_sel)      rdata = {24'h0, sel_q};
        else if (off_win) rdata = win_word;
        else              rdata = '0;
    end

endmodule

// File: rtl/irq_route_regs.sv
// Top of the indirect redirection-table register window.
// Holds the ID register, instantiates one entry per pin, and encodes the
// per-entry strobes onto shared pin-index outputs.
// Assumes a single bus master and one status load per cycle.
module irq_route_regs
    import irw_pkg::*;
#(
    parameter int         PINS    = 24,
    parameter int         ADDR_W  = 12,
    parameter logic [7:0] VERSION = 8'h11,
    localparam int        IDX_W   = $clog2(PINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              stat_we,
    input  logic [IDX_W-1:0]  stat_pin,
    input  logic              stat_rirr,
    input  logic              stat_dlv,
    output logic              mask_evt,
    output logic [IDX_W-1:0]  mask_evt_pin,
    output logic              mask_evt_val,
    output logic              lvl_evt,
    output logic [IDX_W-1:0]  lvl_evt_pin
);

    logic [7:0]         sel_q;
    logic               off_sel;
    logic               off_win;
    win_kind_e          kind;
    logic [IDX_W-1:0]   tbl_idx;
    logic               tbl_hi;
    logic               wr_id;
    logic [PINS-1:0]    wr_lo_vec;
    logic [PINS-1:0]    wr_hi_vec;
    logic [ID_W-1:0]    id_q;
    logic [ENTRY_W-1:0] ent [PINS];
    logic [PINS*ENTRY_W-1:0] ent_flat;
    logic [PINS-1:0]    mask_vec;
    logic [PINS-1:0]    lvl_vec;
    logic [ENTRY_W-1:0] ent_pick;

    irw_decode #(.PINS(PINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .sel_q     (sel_q),
        .off_sel   (off_sel),
        .off_win   (off_win),
        .kind      (kind),
        .tbl_idx   (tbl_idx),
        .tbl_hi    (tbl_hi),
        .wr_id     (wr_id),
        .wr_lo_vec (wr_lo_vec),
        .wr_hi_vec (wr_hi_vec)
    );

    // ID register: 4 bits taken from data bits 27:24
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= '0;
        else if (wr_id)
            id_q <= bus_wdata[ID_LSB +: ID_W];
    end

    for (genvar i = 0; i < PINS; i++) begin : g_ent
        irw_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (wr_lo_vec[i]),
            .wr_hi     (wr_hi_vec[i]),
            .wdata     (bus_wdata),
            .stat_we   (stat_we && (stat_pin == IDX_W'(i))),
            .stat_rirr (stat_rirr),
            .stat_dlv  (stat_dlv),
            .ent       (ent[i]),
            .mask_evt  (mask_vec[i]),
            .lvl_evt   (lvl_vec[i])
        );
        assign ent_flat[i*ENTRY_W +: ENTRY_W] = ent[i];
    end

    // Pick the entry addressed by the select register
    always_comb begin
        ent_pick = '0;
        for (int i = 0; i < PINS; i++)
            if (tbl_idx == IDX_W'(i)) ent_pick = ent[i];
    end

    // Encode per-entry strobes onto the shared outputs
    always_comb begin
        mask_evt_pin = '0;
        mask_evt_val = 1'b0;
        lvl_evt_pin  = '0;
        for (int i = 0; i < PINS; i++) begin
            if (mask_vec[i]) begin
                mask_evt_pin = IDX_W'(i);
                mask_evt_val = ent[i][B_MASK];
            end
            if (lvl_vec[i]) lvl_evt_pin = IDX_W'(i);
        end
    end

    assign mask_evt = |mask_vec;
    assign lvl_evt  = |lvl_vec;

    irw_readmux #(.PINS(PINS), .VERSION(VERSION)) u_rd (
        .off_sel  (off_sel),
        .off_win  (off_win),
        .sel_q    (sel_q),
        .kind     (kind),
        .tbl_hi   (tbl_hi),
        .id_q     (id_q),
        .ent_pick (ent_pick),
        .rdata    (bus_rdata)
    );

    // R10/R11: strobes name a single entry at a time
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_vec) && $onehot0(lvl_vec));

    // R5: a window write with no target leaves every entry as it was
    p_oob_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off_win && kind == WK_NONE && !stat_we) |=> $stable(ent_flat));

    // R3: writes through the arbitration select never move the ID
    p_arb_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off_win && kind == WK_ARB) |=> $stable(id_q));

endmodule

// File: tb/sim_irq_route_regs.sv
// Directed bench for the redirection-table register window.
module sim_irq_route_regs;

    localparam int PINS  = 24;
    localparam int IDX_W = $clog2(PINS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              stat_we = 1'b0;
    logic [IDX_W-1:0]  stat_pin = '0;
    logic              stat_rirr = 1'b0;
    logic              stat_dlv = 1'b0;
    logic              mask_evt;
    logic [IDX_W-1:0]  mask_evt_pin;
    logic              mask_evt_val;
    logic              lvl_evt;
    logic [IDX_W-1:0]  lvl_evt_pin;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_route_regs u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .stat_we      (stat_we),
        .stat_pin     (stat_pin),
        .stat_rirr    (stat_rirr),
        .stat_dlv     (stat_dlv),
        .mask_evt     (mask_evt),
        .mask_evt_pin (mask_evt_pin),
        .mask_evt_val (mask_evt_val),
        .lvl_evt      (lvl_evt),
        .lvl_evt_pin  (lvl_evt_pin)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr_bus(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_bus(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rd_win(input logic [7:0] s, output logic [31:0] v);
        wr_bus(12'h000, {24'h0, s});
        rd_bus(12'h010, v);
    endtask

    task automatic stat_load(input int pin, input logic r, input logic d);
        @(negedge clk);
        stat_we   = 1'b1;
        stat_pin  = IDX_W'(pin);
        stat_rirr = r;
        stat_dlv  = d;
        @(negedge clk);
        stat_we   = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_bus(12'h000, v);      chk("R9 select after reset", v, 32'h0);
        rd_bus(12'h010, v);      chk("R9 ID after reset", v, 32'h0);
        rd_win(8'h10, v);        chk("R9 entry0 lo", v, 32'h0001_0000);
        rd_win(8'h3E, v);        chk("R9 entry23 lo", v, 32'h0001_0000);
        rd_win(8'h3F, v);        chk("R9 entry23 hi", v, 32'h0);
        chk("R9 strobes idle", {30'h0, mask_evt, lvl_evt}, 32'h0);
    endtask

    task automatic t_select;
        logic [31:0] v;
        wr_bus(12'h000, 32'hABCD_1234);
        rd_bus(12'h000, v);      chk("R1 select low byte", v, 32'h34);
        wr_bus(12'h300, 32'h0000_0005);
        rd_bus(12'h000, v);      chk("R8 upper address bits ignored", v, 32'h05);
    endtask

    task automatic t_version;
        logic [31:0] v;
        rd_win(8'h01, v);        chk("R2 version word", v, 32'h0017_0011);
        wr_bus(12'h010, 32'hFFFF_FFFF);
        rd_bus(12'h010, v);      chk("R2 version write ignored", v, 32'h0017_0011);
    endtask

    task automatic t_id;
        logic [31:0] v;
        wr_bus(12'h000, 32'h00);
        wr_bus(12'h010, 32'hA5FF_FFFF);
        rd_bus(12'h010, v);      chk("R3 ID bits 27:24", v, 32'h0500_0000);
        rd_win(8'h02, v);        chk("R3 arbitration reads ID", v, 32'h0500_0000);
        wr_bus(12'h010, 32'h0C00_0000);
        rd_bus(12'h010, v);      chk("R3 arbitration write dropped", v, 32'h0500_0000);
    endtask

    task automatic t_table;
        logic [31:0] v;
        wr_bus(12'h000, 32'h1A);
        wr_bus(12'h010, 32'h0000_8031);
        chk("R10 mask strobe on unmask", {31'h0, mask_evt}, 32'h1);
        chk("R10 mask strobe pin", {27'h0, mask_evt_pin}, 32'd5);
        chk("R10 mask strobe value", {31'h0, mask_evt_val}, 32'h0);
        chk("R11 level strobe", {31'h0, lvl_evt}, 32'h1);
        chk("R11 level strobe pin", {27'h0, lvl_evt_pin}, 32'd5);
        @(negedge clk);
        chk("R10 mask strobe one cycle", {31'h0, mask_evt}, 32'h0);
        chk("R11 level strobe one cycle", {31'h0, lvl_evt}, 32'h0);
        rd_bus(12'h010, v);      chk("R4 entry5 lo readback", v, 32'h0000_8031);
        wr_bus(12'h000, 32'h1B);
        wr_bus(12'h010, 32'hFF00_0000);
        chk("R10 no mask strobe on hi write", {31'h0, mask_evt}, 32'h0);
        chk("R11 level strobe on hi write", {31'h0, lvl_evt}, 32'h1);
        rd_bus(12'h010, v);      chk("R4 entry5 hi readback", v, 32'hFF00_0000);
        wr_bus(12'h000, 32'h3F);
        wr_bus(12'h010, 32'h1234_5678);
        chk("R11 no level strobe on edge entry", {31'h0, lvl_evt}, 32'h0);
        rd_bus(12'h010, v);      chk("R4 entry23 hi readback", v, 32'h1234_5678);
        rd_win(8'h3C, v);        chk("R4 entry22 untouched", v, 32'h0001_0000);
        rd_win(8'h1A, v);        chk("R4 entry5 lo still", v, 32'h0000_8031);
    endtask

    task automatic t_oob;
        logic [31:0] v;
        rd_win(8'h40, v);        chk("R5 index past last pin reads ones", v, 32'hFFFF_FFFF);
        rd_win(8'h05, v);        chk("R5 reserved select reads ones", v, 32'hFFFF_FFFF);
        rd_win(8'hFF, v);        chk("R5 top select reads ones", v, 32'hFFFF_FFFF);
        wr_bus(12'h000, 32'h40);
        wr_bus(12'h010, 32'h0000_0000);
        chk("R5 dropped write no strobe", {30'h0, mask_evt, lvl_evt}, 32'h0);
        rd_win(8'h3E, v);        chk("R5 entry23 unchanged", v, 32'h0001_0000);
        rd_win(8'h10, v);        chk("R5 entry0 unchanged", v, 32'h0001_0000);
    endtask

    task automatic t_offsets;
        logic [31:0] v;
        wr_bus(12'h000, 32'h3E);
        rd_bus(12'h020, v);      chk("R8 unused offset reads 0", v, 32'h0);
        rd_bus(12'h004, v);      chk("R8 offset 0x04 reads 0", v, 32'h0);
        wr_bus(12'h020, 32'h0000_0099);
        wr_bus(12'h014, 32'h0000_0000);
        rd_bus(12'h000, v);      chk("R8 select unchanged", v, 32'h3E);
        rd_bus(12'h010, v);      chk("R8 entry23 unchanged", v, 32'h0001_0000);
    endtask

    task automatic t_status;
        logic [31:0] v;
        stat_load(5, 1'b1, 1'b1);
        rd_win(8'h1A, v);        chk("R12 status load sets bits", v, 32'h0000_D031);
        wr_bus(12'h010, 32'h0000_8031);
        rd_bus(12'h010, v);      chk("R6 level write keeps status", v, 32'h0000_D031);
        wr_bus(12'h010, 32'h0000_5031);
        chk("R11 no level strobe after edge write", {31'h0, lvl_evt}, 32'h0);
        rd_bus(12'h010, v);      chk("R7 edge write clears remote IRR", v, 32'h0000_1031);
        wr_bus(12'h000, 32'h1E);
        wr_bus(12'h010, 32'h0001_D000);
        chk("R10 mask kept no strobe", {31'h0, mask_evt}, 32'h0);
        chk("R11 level strobe pin7", {27'h0, lvl_evt_pin}, 32'd7);
        rd_bus(12'h010, v);      chk("R6 data status bits ignored", v, 32'h0001_8000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_version();
        t_id();
        t_table();
        t_oob();
        t_offsets();
        t_status();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule